// File: doc/BRIEF.md
# Raster Bar Pattern Selector

This block builds square-wave bar patterns that stay locked to the raster, and it routes them bit by bit onto three 4-bit digital colour channels. A pixel counter and a line counter follow the line and field timing strobes. The low bits of each counter act as a family of bar patterns. Each bit of the pixel counter gives vertical stripes, and each bit of the line counter gives horizontal bands, with a period that doubles from one bit to the next. The active raster is 512 pixels wide and 486 lines tall, so the 9-bit counters cover it. The pixel counter wraps at 512 if no line strobe arrives.

Each of the twelve output bits has its own 5-bit source code. The code picks one of the sixteen counter bits, or the bit at the same position of that channel's external digital video word, or a forced zero. A host writes new codes into a pending register at any time. The codes that actually route the outputs are copied from the pending register only while vertical blanking is asserted. As a result, the pattern routing never changes partway through a visible field.

Top module: `raster_bar_select`

## Requirements
- R1: While `rst_n` is low, both counters are cleared and every route code is set to 31. Every `pix_out` bit is therefore 0 during reset and right after it.
- R2: The pixel counter goes up by one on every clock. It is cleared in the clock after which `line_start` was high, and it wraps from 511 to 0.
- R3: The line counter goes up by one on each clock where `line_start` is high. It is cleared on a clock where `field_start` is high, and `field_start` takes priority.
- R4: If a lane's code is k, with k from 0 to 7, the lane outputs bit k of the pixel counter.
- R5: If a lane's code is k, with k from 8 to 15, the lane outputs bit k-8 of the line counter.
- R6: If a lane's code is 16, lane i outputs `ext_video[i]`. This is a combinational path.
- R7: Any code from 17 to 31 forces the lane's output to 0, whatever the external video and the counters hold.
- R8: Lane i is output bit `pix_out[i]`, and it belongs to channel i/4. The code for lane i sits in `ctl_data[5*i+4:5*i]`. Each lane routes on its own, with no effect on the other lanes.
- R9: When `ctl_wr` is high on a clock, `ctl_data` is captured into the pending register. While `vblank` is low, the active codes do not change, so the outputs keep their routing.
- R10: On every clock where `vblank` is high, the active codes take the value the pending register held before that edge. A write made in the same cycle therefore takes effect one blanking clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Line timing strobe, one clock wide |
| field_start | input | 1 | Field timing strobe, one clock wide |
| vblank | input | 1 | High during vertical blanking; enables the code transfer |
| ctl_wr | input | 1 | Host write strobe for the pending codes |
| ctl_data | input | 60 | Twelve 5-bit route codes, lane i at bits 5i+4..5i |
| ext_video | input | 12 | External digital video, three 4-bit words |
| pix_out | output | 12 | Three 4-bit output channels |

## Verification
The hardest behaviour to reach from the ports is the upper line-counter bits. These bits only move after hundreds of lines, and they can be seen only through lanes that are routed to them. The stimulus routes every lane to a line-counter bit. It then sends `line_start` every third clock, which carries the line count past 486 before a `field_start` clears it. Pixel wrap is reached the same way, by holding `line_start` low for more than 512 clocks. The blanking handover is tested with a write during active video, and with a write in the same cycle as blanking.

// File: rtl/raster_bar_select.sv
module raster_bar_select #(
  parameter int H_BITS = 9,
  parameter int V_BITS = 9,
  parameter int PATS   = 8,
  parameter int WIDTH  = 4,
  parameter int GROUPS = 3,
  parameter int SEL_W  = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            line_start,
  input  logic                            field_start,
  input  logic                            vblank,
  input  logic                            ctl_wr,
  input  logic [GROUPS*WIDTH*SEL_W-1:0]   ctl_data,
  input  logic [GROUPS*WIDTH-1:0]         ext_video,
  output logic [GROUPS*WIDTH-1:0]         pix_out
);
  localparam int LANES    = GROUPS * WIDTH;
  localparam int CTL_W    = LANES * SEL_W;
  localparam int NPAT     = 2 * PATS;
  localparam int IDX_W    = $clog2(NPAT);
  localparam logic [SEL_W-1:0] EXT_CODE = SEL_W'(NPAT);

  logic [H_BITS-1:0] hcnt;
  logic [V_BITS-1:0] vcnt;
  logic [CTL_W-1:0]  sel_pend, sel_act;
  logic [NPAT-1:0]   pats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= line_start ? '0 : hcnt + 1'b1;
      if (field_start)     vcnt <= '0;
      else if (line_start) vcnt <= vcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_pend <= '1;
      sel_act  <= '1;
    end else begin
      if (ctl_wr) sel_pend <= ctl_data;
      if (vblank) sel_act  <= sel_pend;
    end
  end

  assign pats = {vcnt[PATS-1:0], hcnt[PATS-1:0]};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SEL_W-1:0] code;
    assign code = sel_act[i*SEL_W +: SEL_W];
    assign pix_out[i] = (code < SEL_W'(NPAT)) ? pats[code[IDX_W-1:0]] :
                        (code == EXT_CODE)    ? ext_video[i] : 1'b0;

    p_force_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (code > EXT_CODE) |-> !pix_out[i]);
    p_ext_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (code == EXT_CODE) |-> (pix_out[i] == ext_video[i]));
  end

  p_hclear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (hcnt == '0));
  p_hwrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && hcnt == '1) |=> (hcnt == '0));
  p_vclear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> (vcnt == '0));
  p_vhold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && !field_start) |=> $stable(vcnt));
  p_route_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank |=> $stable(sel_act));
  p_route_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |=> (sel_act == $past(sel_pend)));
endmodule

// File: tb/raster_bar_select_tb.sv
`timescale 1ns/1ps
module raster_bar_select_tb;
  localparam int LANES = 12;
  localparam int CW = 60;

  logic clk = 0, rst_n = 0;
  logic ls = 0, fs = 0, vb = 0, wr = 0;
  logic [CW-1:0] wdata = '0;
  logic [LANES-1:0] ext = '0;
  logic [LANES-1:0] pix_out;

  int checks = 0, errors = 0;
  logic [CW-1:0] pend_m = '1, act_m = '1;
  int h_m = 0, v_m = 0;

  always #2.5 clk = ~clk;

  raster_bar_select u_dut (
    .clk(clk), .rst_n(rst_n), .line_start(ls), .field_start(fs),
    .vblank(vb), .ctl_wr(wr), .ctl_data(wdata), .ext_video(ext),
    .pix_out(pix_out));

  function automatic logic [LANES-1:0] model(logic [CW-1:0] a, int h, int v,
                                             logic [LANES-1:0] e);
    logic [LANES-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      int c;
      c = int'(a[i*5 +: 5]);
      if (c < 8)       r[i] = 1'((h >> c) & 1);
      else if (c < 16) r[i] = 1'((v >> (c - 8)) & 1);
      else if (c == 16) r[i] = e[i];
      else             r[i] = 1'b0;
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [LANES-1:0] got, logic [LANES-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h h=%0d v=%0d", tag, got, exp, h_m, v_m);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) begin
      if (vb) act_m = pend_m;
      if (wr) pend_m = wdata;
      if (fs) v_m = 0;
      else if (ls) v_m = (v_m + 1) % 512;
      h_m = ls ? 0 : (h_m + 1) % 512;
    end
    #1;
  endtask

  task automatic run(string tag);
    tick();
    chk(tag, pix_out, model(act_m, h_m, v_m, ext));
  endtask

  task automatic apply(logic [CW-1:0] cfg);
    ls = 0; fs = 0;
    wdata = cfg; wr = 1;
    run("R9");
    wr = 0;
    run("R9");
    vb = 1;
    run("R10");
    vb = 0;
  endtask

  function automatic logic [CW-1:0] mk(int c0, int step, int base_mod, int base);
    logic [CW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*5 +: 5] = 5'(base + ((c0 + i * step) % base_mod));
    return r;
  endfunction

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    chk("R1", pix_out, '0);
    tick(); tick();
    chk("R1", pix_out, '0);
    rst_n = 1;
    run("R1");
    chk("R1", pix_out, '0);

    // R4 and R2: pixel counter bits, no line strobe so the counter wraps
    apply(mk(0, 1, 8, 0));
    for (int n = 0; n < 1100; n++) run("R2/R4");
    ls = 1; run("R2"); ls = 0;
    for (int n = 0; n < 20; n++) run("R2");

    // R5 and R3: line counter bits, short lines
    apply(mk(0, 1, 8, 8));
    for (int n = 0; n < 3000; n++) begin
      ls = (n % 3 == 0);
      fs = (n == 1800);
      run("R3/R5");
    end
    ls = 0; fs = 0;

    // R6: external bits, full sweep
    apply({LANES{5'd16}});
    for (int x = 0; x < 4096; x++) begin
      ext = 12'(x);
      run("R6");
    end

    // R7: unused codes force zero
    apply(mk(0, 1, 15, 17));
    for (int n = 0; n < 300; n++) begin
      ext = 12'(n * 37 + 5);
      ls = (n % 5 == 0);
      run("R7");
      if (pix_out !== '0) chk("R7", pix_out, '0);
    end
    ls = 0;

    // R8: distinct routing per channel
    begin
      logic [CW-1:0] c;
      c = '0;
      for (int i = 0; i < 4; i++) begin
        c[i*5 +: 5]      = 5'd16;
        c[(4+i)*5 +: 5]  = 5'((5 + i) % 8);
        c[(8+i)*5 +: 5]  = 5'(15 - i);
      end
      apply(c);
    end
    for (int n = 0; n < 2000; n++) begin
      ext = 12'(n * 113);
      ls = (n % 2 == 0);
      run("R8");
    end
    ls = 0;

    // R9: write during active video leaves routing alone
    wdata = {LANES{5'd31}}; wr = 1; run("R9"); wr = 0;
    for (int n = 0; n < 50; n++) run("R9");
    // R10: blanking transfers the pending codes
    vb = 1; run("R10"); vb = 0;
    chk("R10", pix_out, '0);
    // R10: write in the same cycle as blanking lands one blanking clock later
    wdata = {LANES{5'd16}}; ext = 12'hA5C;
    vb = 1; wr = 1; run("R10");
    chk("R10", pix_out, '0);
    wr = 0; run("R10");
    chk("R10", pix_out, 12'hA5C);
    vb = 0;
    for (int n = 0; n < 10; n++) run("R10");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule